// File: doc/BRIEF.md
# On-Screen Display Dot Mixer

This block forms the final pixel stream of a character overlay. For each dot clock it takes the glyph dot at the current position, the four glyph dots next to it, the cell's attribute bit and character code, and the index of the text row being drawn. From these it drives two independent output systems. Each system has a character line and a blanking line. Font lookup and raster timing are done upstream. The block only decides, dot by dot, what each system shows.

A set of static control bits shapes the result. One turns the display on. Others enable reverse video and per-character blinking, with two blink rates. A border option places blanking around the glyph strokes. A blank-only option keeps character dots off the blanking line. A routing option makes the two systems mutually exclusive. A 12-bit row mask decides which rows appear on the second system. The blink timebase advances once per field pulse. Every output is registered once.

Top module: `osd_dot_mixer`

## Requirements
- R1: When `disp_en` is 0, all four outputs are 0 one clock later.
- R2: For a visible, unreversed cell, the character output equals the glyph dot. With `blank_only` = 0, the blanking output equals the glyph dot OR'd with the border term.
- R3: When `attr_in` = 1, `rev_en` = 1 and the cell is not in its blink-alternate phase, the character output is the inverse of the glyph dot and the whole cell is blanking region.
- R4: The blink phase starts at 0 after reset. Each field pulse adds one to a field count. When the count reaches 15 (`blink_slow` = 0) or 30 (`blink_slow` = 1), the phase toggles and the count restarts. This gives a 50% duty cycle.
- R5: When `blink_en` = 1, `attr_in` = 1 and the blink phase is 1, a cell without reverse video shows nothing on either output. A cell with reverse video is shown with its normal appearance instead.
- R6: With `blank_only` = 1, the blanking output is the blanking region minus the dots on the character output. With `blank_only` = 0, the blanking output is the blanking region including the character dots.
- R7: With `border_en` = 1, a dot that is not lit but has any lit neighbour in `nbr_dots` (left, right, up, down, in any bit order) is in the blanking region. With `border_en` = 0, neighbours have no effect.
- R8: System 2 outputs row r only when `sys2_rows[r]` is 1 (bit r is row r). Rows 12 and above are output on neither system.
- R9: With `sys1_excl` = 0, system 1 outputs every valid row. With `sys1_excl` = 1, system 1 outputs only the rows whose `sys2_rows` bit is 0.
- R10: A cell whose `char_code` is 7'h7F drives 0 on every output, whatever its dots or attribute.
- R11: All outputs are 0 during reset. Each output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_pulse | input | 1 | One-cycle pulse per video field; drives the blink timebase |
| dot_in | input | 1 | Glyph dot at the current position |
| nbr_dots | input | 4 | Glyph dots of the four adjacent positions |
| attr_in | input | 1 | Per-character attribute bit (reverse/blink) |
| char_code | input | 7 | Character code of the current cell |
| row_idx | input | 4 | Text row being drawn (0 to 11 valid) |
| disp_en | input | 1 | Display on |
| rev_en | input | 1 | Reverse video enable for attributed cells |
| blink_slow | input | 1 | Blink half-period select: 0 = 15 fields, 1 = 30 fields |
| blink_en | input | 1 | Blink enable for attributed cells |
| border_en | input | 1 | Border around glyph strokes |
| blank_only | input | 1 | Keep character dots off the blanking outputs |
| sys1_excl | input | 1 | System 1 skips rows routed to system 2 |
| sys2_rows | input | 12 | Per-row enable for system 2 |
| cha1 | output | 1 | System 1 character output |
| blk1 | output | 1 | System 1 blanking output |
| cha2 | output | 1 | System 2 character output |
| blk2 | output | 1 | System 2 blanking output |

## Verification
The assertions check the properties that must hold on every cycle. These are: the display-off blackout, the empty-code blackout, the row mask gating system 2, exclusive routing, the blank-only split between the two lines of each system, and the blink counter. The counter may change phase only on a field pulse and must stay below its limit. The exact dot values cannot be checked that way. These are the inversion under reverse video, the border halo, and the hide-versus-alternate choice at the blink boundary. They also include the exact field count at which the phase flips for each rate. These show up only in the bench's directed scenarios and in its randomized mix, checked against a reference model.

// File: rtl/osd_mix_pkg.sv
package osd_mix_pkg;

    typedef struct packed {
        logic disp_en;
        logic rev_en;
        logic blink_slow;
        logic blink_en;
        logic border_en;
        logic blank_only;
        logic sys1_excl;
    } mix_ctrl_t;

    typedef struct packed {
        logic cha;
        logic blk;
    } sys_out_t;

    localparam logic [6:0] EMPTY_CODE = 7'h7F;

endpackage

// File: rtl/osd_blink_timer.sv
module osd_blink_timer #(
    parameter int FAST_FIELDS = 15,
    parameter int SLOW_FIELDS = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic field_pulse,
    input  logic slow_sel,
    output logic phase
);
    localparam int CW = $clog2(SLOW_FIELDS + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          phase;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [CW-1:0] limit;

    always_comb begin
        st_d  = st_q;
        limit = slow_sel ? CW'(SLOW_FIELDS - 1) : CW'(FAST_FIELDS - 1);
        if (field_pulse) begin
            if (st_q.cnt >= limit) begin
                st_d.cnt   = '0;
                st_d.phase = ~st_q.phase;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase = st_q.phase;

    assert_phase_only_on_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !field_pulse |=> $stable(st_q.phase));

    assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CW'(SLOW_FIELDS));

endmodule

// File: rtl/osd_dot_shaper.sv
module osd_dot_shaper
    import osd_mix_pkg::*;
#(
    parameter int NBR = 4
) (
    input  logic           dot,
    input  logic [NBR-1:0] nbr,
    input  logic           attr,
    input  logic [6:0]     code,
    input  mix_ctrl_t      ctrl,
    input  logic           blink_phase,
    output sys_out_t       px
);
    logic empty, hide, reversed, region, cha;

    always_comb begin
        empty    = (code == EMPTY_CODE);
        hide     = attr & ctrl.blink_en & blink_phase;
        reversed = attr & ctrl.rev_en & ~hide;
        cha      = 1'b0;
        region   = 1'b0;
        if (!empty) begin
            if (reversed) begin
                cha    = ~dot;
                region = 1'b1;
            end else if (!(hide && !ctrl.rev_en)) begin
                cha    = dot;
                region = dot | (ctrl.border_en & (|nbr));
            end
        end
        px.cha = cha;
        px.blk = ctrl.blank_only ? (region & ~cha) : (region | cha);
    end

endmodule

// File: rtl/osd_row_router.sv
module osd_row_router #(
    parameter int ROWS  = 12,
    parameter int ROW_W = $clog2(ROWS)
) (
    input  logic [ROW_W-1:0] row,
    input  logic [ROWS-1:0]  mask,
    input  logic             excl,
    output logic             en1,
    output logic             en2
);
    localparam int PADW = 2 ** ROW_W;

    logic [PADW-1:0] mask_ext;
    logic            row_ok;
    logic            sel2;

    always_comb begin
        mask_ext = PADW'(mask);
        row_ok   = ({1'b0, row} < (ROW_W + 1)'(ROWS));
        sel2     = row_ok & mask_ext[row];
        en2      = sel2;
        en1      = row_ok & ~(excl & sel2);
    end

endmodule

// File: rtl/osd_dot_mixer.sv
module osd_dot_mixer
    import osd_mix_pkg::*;
#(
    parameter int ROWS        = 12,
    parameter int NBR         = 4,
    parameter int FAST_FIELDS = 15,
    parameter int SLOW_FIELDS = 30,
    localparam int ROW_W      = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             field_pulse,
    input  logic             dot_in,
    input  logic [NBR-1:0]   nbr_dots,
    input  logic             attr_in,
    input  logic [6:0]       char_code,
    input  logic [ROW_W-1:0] row_idx,
    input  logic             disp_en,
    input  logic             rev_en,
    input  logic             blink_slow,
    input  logic             blink_en,
    input  logic             border_en,
    input  logic             blank_only,
    input  logic             sys1_excl,
    input  logic [ROWS-1:0]  sys2_rows,
    output logic             cha1,
    output logic             blk1,
    output logic             cha2,
    output logic             blk2
);
    localparam int PADW = 2 ** ROW_W;

    typedef struct packed {
        sys_out_t s1;
        sys_out_t s2;
    } out_t;

    mix_ctrl_t ctrl;
    sys_out_t  px;
    logic      phase, en1, en2;
    out_t      out_d, out_q;

    assign ctrl = '{disp_en: disp_en, rev_en: rev_en, blink_slow: blink_slow,
                    blink_en: blink_en, border_en: border_en,
                    blank_only: blank_only, sys1_excl: sys1_excl};

    osd_blink_timer #(.FAST_FIELDS(FAST_FIELDS), .SLOW_FIELDS(SLOW_FIELDS)) timer_i (
        .clk(clk), .rst_n(rst_n), .field_pulse(field_pulse),
        .slow_sel(blink_slow), .phase(phase)
    );

    osd_dot_shaper #(.NBR(NBR)) shaper_i (
        .dot(dot_in), .nbr(nbr_dots), .attr(attr_in), .code(char_code),
        .ctrl(ctrl), .blink_phase(phase), .px(px)
    );

    osd_row_router #(.ROWS(ROWS), .ROW_W(ROW_W)) router_i (
        .row(row_idx), .mask(sys2_rows), .excl(sys1_excl), .en1(en1), .en2(en2)
    );

    always_comb begin
        out_d = '0;
        if (ctrl.disp_en) begin
            if (en1) out_d.s1 = px;
            if (en2) out_d.s2 = px;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign cha1 = out_q.s1.cha;
    assign blk1 = out_q.s1.blk;
    assign cha2 = out_q.s2.cha;
    assign blk2 = out_q.s2.blk;

    function automatic logic row_on_sys2(input logic [ROW_W-1:0] r, input logic [ROWS-1:0] m);
        logic [PADW-1:0] mx;
        mx = PADW'(m);
        return ({1'b0, r} < (ROW_W + 1)'(ROWS)) && mx[r];
    endfunction

    assert_display_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |=> !(cha1 | blk1 | cha2 | blk2));

    assert_blank_excludes_char_R6: assert property (@(posedge clk) disable iff (!rst_n)
        blank_only |=> !(cha1 & blk1) && !(cha2 & blk2));

    assert_sys2_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !row_on_sys2(row_idx, sys2_rows) |=> !(cha2 | blk2));

    assert_exclusive_routing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sys1_excl |=> !((cha1 | blk1) && (cha2 | blk2)));

    assert_empty_cell_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (char_code == EMPTY_CODE) |=> !(cha1 | blk1 | cha2 | blk2));

endmodule

// File: tb/osd_dot_mixer_tb.sv
module osd_dot_mixer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        field_pulse = 1'b0;
    logic        dot_in = 1'b0;
    logic [3:0]  nbr_dots = '0;
    logic        attr_in = 1'b0;
    logic [6:0]  char_code = 7'h10;
    logic [3:0]  row_idx = '0;
    logic        disp_en = 1'b0, rev_en = 1'b0, blink_slow = 1'b0, blink_en = 1'b0;
    logic        border_en = 1'b0, blank_only = 1'b0, sys1_excl = 1'b0;
    logic [11:0] sys2_rows = '0;
    logic        cha1, blk1, cha2, blk2;

    int checks = 0;
    int errors = 0;
    int m_cnt = 0;
    logic m_phase = 1'b0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    osd_dot_mixer dut_i (
        .clk(clk), .rst_n(rst_n), .field_pulse(field_pulse), .dot_in(dot_in),
        .nbr_dots(nbr_dots), .attr_in(attr_in), .char_code(char_code),
        .row_idx(row_idx), .disp_en(disp_en), .rev_en(rev_en),
        .blink_slow(blink_slow), .blink_en(blink_en), .border_en(border_en),
        .blank_only(blank_only), .sys1_excl(sys1_excl), .sys2_rows(sys2_rows),
        .cha1(cha1), .blk1(blk1), .cha2(cha2), .blk2(blk2)
    );

    function automatic logic [3:0] model();
        logic c, reg_on, b, hide, rv, on1, on2, in2;
        c = 1'b0; reg_on = 1'b0;
        hide = attr_in & blink_en & m_phase;
        rv   = attr_in & rev_en & ~hide;
        if (char_code != 7'h7F) begin
            if (rv) begin
                c = ~dot_in; reg_on = 1'b1;
            end else if (!(hide && !rev_en)) begin
                c = dot_in; reg_on = dot_in | (border_en & (|nbr_dots));
            end
        end
        b   = blank_only ? (reg_on & ~c) : (reg_on | c);
        in2 = (row_idx < 12) && sys2_rows[row_idx];
        on2 = disp_en && in2;
        on1 = disp_en && (row_idx < 12) && !(sys1_excl && in2);
        return {on1 & c, on1 & b, on2 & c, on2 & b};
    endfunction

    task automatic check(input string req, input logic [3:0] exp);
        checks++;
        if ({cha1, blk1, cha2, blk2} !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, {cha1, blk1, cha2, blk2}, exp);
        end
    endtask

    task automatic step(input string req);
        logic [3:0] e;
        e = model();
        @(posedge clk); #1;
        check(req, e);
        @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            field_pulse = 1'b1;
            @(posedge clk); #1;
            field_pulse = 1'b0;
            if (m_cnt >= (blink_slow ? 29 : 14)) begin
                m_cnt = 0; m_phase = ~m_phase;
            end else m_cnt++;
            @(negedge clk);
        end
    endtask

    task automatic set_base();
        disp_en = 1; rev_en = 0; blink_en = 0; border_en = 0; blank_only = 0;
        sys1_excl = 0; sys2_rows = '0; attr_in = 0; char_code = 7'h21;
        row_idx = 0; dot_in = 0; nbr_dots = '0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1234));
        dot_in = 1; disp_en = 1;
        repeat (3) @(negedge clk);
        check("R11 reset", 4'b0000);
        rst_n = 1;
        @(negedge clk);

        set_base(); dot_in = 1;
        step("R2 lit dot");
        dot_in = 0;
        step("R2 dark dot");
        disp_en = 0; dot_in = 1; attr_in = 1; rev_en = 1;
        step("R1 display off");
        set_base(); dot_in = 1; char_code = 7'h7F; attr_in = 1; rev_en = 1;
        step("R10 empty code");
        set_base(); nbr_dots = 4'b0100; border_en = 1;
        step("R7 border halo");
        border_en = 0;
        step("R7 border off");
        border_en = 1; blank_only = 1; dot_in = 1;
        step("R6 blank only lit");
        dot_in = 0;
        step("R6 blank only halo");
        set_base(); attr_in = 1; rev_en = 1; dot_in = 0;
        step("R3 reverse dark");
        dot_in = 1;
        step("R3 reverse lit");
        set_base(); dot_in = 1; row_idx = 3; sys2_rows = 12'h008;
        step("R8 row on sys2");
        row_idx = 4;
        step("R8 row off sys2");
        row_idx = 12; sys2_rows = 12'hFFF;
        step("R8 invalid row");
        row_idx = 3; sys2_rows = 12'h008; sys1_excl = 1;
        step("R9 exclusive");
        row_idx = 5;
        step("R9 exclusive other row");

        set_base(); dot_in = 1; attr_in = 1; blink_en = 1; blink_slow = 0;
        pulses(14);
        step("R4 visible before 15 fields");
        pulses(1);
        step("R5 hidden blink");
        rev_en = 1; dot_in = 0;
        step("R5 reverse alternates to normal");
        pulses(15);
        step("R4 back after 15 fields");
        blink_slow = 1; rev_en = 0; dot_in = 1;
        pulses(29);
        step("R4 slow not yet");
        pulses(1);
        step("R4 slow toggle at 30");

        for (int i = 0; i < 3000; i++) begin
            if (i % 200 == 199) pulses($urandom_range(1, 20));
            disp_en    = ($urandom_range(0, 7) != 0);
            rev_en     = $urandom_range(0, 1);
            blink_en   = $urandom_range(0, 1);
            border_en  = $urandom_range(0, 1);
            blank_only = $urandom_range(0, 1);
            sys1_excl  = $urandom_range(0, 1);
            sys2_rows  = 12'($urandom);
            attr_in    = $urandom_range(0, 1);
            char_code  = ($urandom_range(0, 9) == 0) ? 7'h7F : 7'($urandom);
            row_idx    = 4'($urandom_range(0, 13));
            dot_in     = $urandom_range(0, 1);
            nbr_dots   = 4'($urandom);
            step("R11 random mix");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule